// File: doc/BRIEF.md
# Local Bus Request Deadlock Timer

This block breaks a local-bus deadlock. The deadlock forms when a slave-side transfer is waiting for the bus while a master-side local access is already in progress but cannot get the grant. The block counts the clocks during which all three conditions hold: a slave hold request is pending, a master access is running, and grant is absent. When that count reaches a programmed delay, the block raises a bus-request output. The surrounding arbiter uses this output to step back and let the slave side through.

The delay is a 4-bit field in units of eight clocks. A separate enable bit gates the output. Both are written through a small control port. Once the request is raised it is latched, and it drops only when grant arrives or when the enable bit is written to 0. Any break in the stall before the threshold restarts the count from zero.

Top module: `dlk_breq_timer`

## Requirements
- R1: After reset the delay field and the enable bit are 0 and `breq_out` is low. Until the enable bit is written, a stall of any length leaves `breq_out` low.
- R2: A write with `cfg_we` high stores `cfg_wdata[3:0]` as the delay D and `cfg_wdata[4]` as the enable bit.
- R3: A stalled clock is one where `slave_hold_pend`=1, `master_busy`=1 and `bus_grant`=0. With enable=1 and an unbroken stall starting at clock edge 1, `breq_out` rises just after edge 8*D+1. For D=0 this is the first stalled clock.
- R4: A clock that is not stalled clears the stall count. A fresh unbroken stall then needs the full 8*D+1 edges again.
- R5: Once high, `breq_out` stays high while grant is absent and enable stays 1, even after the stall condition clears.
- R6: `bus_grant` high at a clock edge makes `breq_out` low after that edge and clears the stall count.
- R7: With the enable bit at 0, `breq_out` never asserts. A write that clears the enable bit drops `breq_out` at the same edge.
- R8: `breq_out` rises only after a clock edge at which the stall condition held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Bit 4 = enable, bits 3:0 = delay in units of 8 clocks |
| slave_hold_pend | input | 1 | Slave-side hold request is pending |
| master_busy | input | 1 | Master-side local access is in progress |
| bus_grant | input | 1 | Local bus grant (hold acknowledge) |
| breq_out | output | 1 | Deadlock-breaking bus request |

## Verification
A stall counter that fails to clear, or that counts the wrong clocks, shows at the ports as a shift in the edge at which `breq_out` rises. The shift is visible within one threshold window (at most 121 clocks), so measuring the exact rise latency for several delays exposes it. A latch fault shows within one clock: the output either drops as soon as the stall ends, or stays high after the grant edge. Errors in the enable or reset state show up as a rise during a long stall that should produce none.

// File: rtl/dlk_pkg.sv
package dlk_pkg;
  // Number of clocks represented by a delay field value, given log2 of the unit.
  function automatic int unsigned thresh_cycles(input int unsigned delay_val,
                                                input int unsigned unit_log2);
    return delay_val << unit_log2;
  endfunction

  // Stalled clock: slave waiting, master busy, no grant.
  function automatic logic is_stalled(input logic hold_pend, input logic mbusy,
                                      input logic grant);
    return hold_pend & mbusy & ~grant;
  endfunction
endpackage

// File: rtl/dlk_cfg_reg.sv
module dlk_cfg_reg #(
  parameter int unsigned DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [DELAY_W:0]   wdata,
  output logic [DELAY_W-1:0] delay_q,
  output logic               en_q,
  output logic               en_next
);
  localparam int unsigned EN_BIT = DELAY_W;

  assign en_next = we ? wdata[EN_BIT] : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q <= '0;
      en_q    <= 1'b0;
    end else if (we) begin
      delay_q <= wdata[DELAY_W-1:0];
      en_q    <= wdata[EN_BIT];
    end
  end

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (delay_q == $past(wdata[DELAY_W-1:0])));
endmodule

// File: rtl/dlk_stall_counter.sv
module dlk_stall_counter #(
  parameter int unsigned DELAY_W   = 4,
  parameter int unsigned UNIT_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stalled,
  input  logic               grant,
  input  logic [DELAY_W-1:0] delay,
  output logic               thresh_hit
);
  import dlk_pkg::*;
  localparam int unsigned CNT_W   = DELAY_W + UNIT_LOG2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit      = CNT_W'(thresh_cycles(int'(delay), UNIT_LOG2));
  assign thresh_hit = stalled && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (grant || !stalled) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  // R4
  stall_break_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stalled |=> (cnt_q == '0));
  // R6
  grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (cnt_q == '0));
endmodule

// File: rtl/dlk_req_latch.sv
module dlk_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic grant,
  input  logic en_next,
  output logic req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 req_q <= 1'b0;
    else if (grant || !en_next) req_q <= 1'b0;
    else if (set_req)           req_q <= 1'b1;
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !grant && en_next) |=> req_q);
  // R6
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !req_q);
endmodule

// File: rtl/dlk_breq_timer.sv
module dlk_breq_timer #(
  parameter int unsigned DELAY_W   = 4,
  parameter int unsigned UNIT_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DELAY_W:0] cfg_wdata,
  input  logic             slave_hold_pend,
  input  logic             master_busy,
  input  logic             bus_grant,
  output logic             breq_out
);
  import dlk_pkg::*;

  logic [DELAY_W-1:0] delay_q;
  logic               en_q;
  logic               en_next;
  logic               stalled;
  logic               thresh_hit;
  logic               set_req;

  assign stalled = is_stalled(slave_hold_pend, master_busy, bus_grant);
  assign set_req = en_q && thresh_hit;

  dlk_cfg_reg #(.DELAY_W(DELAY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .delay_q(delay_q), .en_q(en_q), .en_next(en_next)
  );

  dlk_stall_counter #(.DELAY_W(DELAY_W), .UNIT_LOG2(UNIT_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .stalled(stalled), .grant(bus_grant),
    .delay(delay_q), .thresh_hit(thresh_hit)
  );

  dlk_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .grant(bus_grant),
    .en_next(en_next), .req_q(breq_out)
  );

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !breq_out);
  // R8
  rise_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(breq_out) |-> $past(slave_hold_pend && master_busy && !bus_grant));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !breq_out);
endmodule

// File: tb/sim_dlk_breq_timer.sv
module sim_dlk_breq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       slave_hold_pend = 1'b0;
  logic       master_busy = 1'b0;
  logic       bus_grant = 1'b0;
  logic       breq_out;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  dlk_breq_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .slave_hold_pend(slave_hold_pend), .master_busy(master_busy),
    .bus_grant(bus_grant), .breq_out(breq_out)
  );

  typedef struct packed {
    logic [3:0] delay;
    logic [7:0] edges;  // expected edges to rise = 8*delay+1
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 8'd1}, '{4'd1, 8'd9}, '{4'd2, 8'd17},
    '{4'd3, 8'd25}, '{4'd5, 8'd41}, '{4'd15, 8'd121}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(input logic en, input logic [3:0] d);
    cfg_we = 1'b1;
    cfg_wdata = {en, d};
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic grant_pulse();
    slave_hold_pend = 1'b0;
    master_busy = 1'b0;
    bus_grant = 1'b1;
    tick(1);
    bus_grant = 1'b0;
  endtask

  // Stall from now on; return edges until breq_out seen high (0 = never within lim).
  task automatic measure(input int lim, output int edges);
    slave_hold_pend = 1'b1;
    master_busy = 1'b1;
    edges = 0;
    for (int i = 1; i <= lim; i++) begin
      tick(1);
      if (breq_out) begin
        edges = i;
        break;
      end
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int e;
    @(negedge clk);
    check("R1 reset", int'(breq_out), 0);
    rst_n = 1'b1;
    tick(1);

    // R1: long stall without any write: enable resets to 0
    measure(200, e);
    check("R1 no-enable stall", e, 0);
    slave_hold_pend = 0; master_busy = 0;
    tick(2);

    // R2 R3: table of delays, exact latency
    foreach (VECS[k]) begin
      write_cfg(1'b1, VECS[k].delay);
      measure(200, e);
      check($sformatf("R3 latency D=%0d", VECS[k].delay), e, int'(VECS[k].edges));
      grant_pulse();
      check("R6 grant drop", int'(breq_out), 0);
      tick(1);
    end

    // R4: break before threshold restarts the count
    write_cfg(1'b1, 4'd2);
    slave_hold_pend = 1; master_busy = 1;
    tick(10);
    master_busy = 0;
    tick(1);
    check("R4 no rise on break", int'(breq_out), 0);
    measure(200, e);
    check("R4 full restart", e, 17);

    // R5: holds after the stall clears, grant absent
    slave_hold_pend = 0; master_busy = 0;
    tick(20);
    check("R5 latched hold", int'(breq_out), 1);

    // R6: grant clears request and count
    grant_pulse();
    check("R6 grant clear", int'(breq_out), 0);
    measure(200, e);
    check("R6 count cleared", e, 17);

    // R7: clearing enable drops request at the same edge
    write_cfg(1'b0, 4'd2);
    check("R7 disable drops", int'(breq_out), 0);
    measure(60, e);
    check("R7 disabled stall", e, 0);

    // R3: enable set mid-stall with D=0 rises on next stalled clock
    write_cfg(1'b1, 4'd0);
    check("R3 enable then D0 first edge", int'(breq_out), 0);
    tick(1);
    check("R3 D0 next stalled clock", int'(breq_out), 1);
    grant_pulse();

    // R8: grant held with hold+busy is not a stall
    write_cfg(1'b1, 4'd0);
    slave_hold_pend = 1; master_busy = 1; bus_grant = 1;
    tick(5);
    check("R8 grant blocks stall", int'(breq_out), 0);
    bus_grant = 0;
    slave_hold_pend = 0;
    tick(5);
    check("R8 one-sided no rise", int'(breq_out), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule